// File: doc/BRIEF.md
# Asynchronous Serial Port with Frame-Start Flag Bit

This block is a full-duplex asynchronous serial port for a controller that talks over a shared multidrop line. A programmable divider turns the system clock into an oversampling tick, and both directions run at 16 ticks per bit. A character holds 7 or 8 data bits. In flag mode, one extra bit is inserted after the data bits, in the slot where the stop bit would otherwise sit. Software sets that bit to mark the first byte of a message frame. The stop bit follows it. The port does not generate parity and never sends more than one stop bit.

Software drives the port through four byte-wide registers, selected by a 2-bit address:

| Address | Write | Read |
|---|---|---|
| 0 | Queue a byte with flag bit 0 | Received byte; the read clears the receive flags |
| 1 | Queue a byte with flag bit 1 | Status |
| 2 | Control | Control |
| 3 | Baud divider | Baud divider |

The transmitter has a one-byte holding register in front of its shift register. The `tx_idle` output goes high only once the holding register is empty and the stop bit of the last byte has fully left the line. A half-duplex RS-485 driver can therefore be turned around on `tx_idle` without cutting off the final byte.

Top module: `flagged_async_serial`

## Requirements
- R1: After reset, `txd` and `tx_idle` are 1, status reads 0x30, control reads 0x00 and the divider reads 0x01.
- R2: Every transmitted bit lasts exactly 16*(D+1) clock cycles, where D is the divider value and a divider of 0 acts as 1. The fastest bit rate is therefore the clock divided by 32.
- R3: A frame is a low start bit, then the data bits LSB first, then one high stop bit. The line rests high between frames.
- R4: With control bit 0 set, 7 data bits are sent and bit 7 of the written byte is not sent. A received character then reads back with bit 7 = 0.
- R5: With control bit 1 set (flag mode), one bit is sent between the last data bit and the stop bit. It is 1 for a byte written to address 1 and 0 for a byte written to address 0.
- R6: Status bit 4 (holding register empty) returns to 1 once the byte moves into the shifter. Status bit 5 and `tx_idle` stay 0 until the stop bit of the last queued byte has completed.
- R7: A write to address 0 or 1 while the holding register is full is dropped: that byte is never sent.
- R8: A received character is readable at address 0 and sets status bit 0 (data ready). Reading address 0 clears status bits 0, 1 and 2.
- R9: In flag mode, status bit 3 holds the received value of the flag bit. Outside flag mode it reads 0.
- R10: If a character completes while status bit 0 is still set, status bit 1 (overrun) is set and the earlier byte is kept. If the data register was read before the next character completes, that character is delivered with no overrun.
- R11: If the stop position samples low, status bit 2 (framing error) is set and the byte is still delivered.
- R12: A low pulse shorter than half a bit on an idle receive line does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; clears the receive flags when addressing 0 |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_idle | output | 1 | High when nothing is queued and the last stop bit has finished |

## Verification
The receive side has two actions that can collide: a character arriving in the receiver, and the host reading the data register. A read clears the ready state, while an arrival either delivers a new byte or records an overrun, depending on whether data is already waiting. The bench sends a second character and reads the first one while the second is still on the line. It then expects the second byte to be delivered with no overrun. It also runs the opposite order, where the read comes only after both characters have arrived, and expects the first byte to be kept with the overrun flag raised. On the transmit side, the bench writes into the holding register while the shifter is busy and then writes again into the full register. It judges the result by the frames that actually appear on `txd`.

// File: rtl/fas_pkg.sv
// Shared constants and types for the flagged asynchronous serial port.
// Assumes: 16x oversampling in both directions; register map of four bytes.
package fas_pkg;
    localparam int OVS = 16;

    localparam logic [1:0] ADR_DATA  = 2'd0;
    localparam logic [1:0] ADR_FLAG  = 2'd1;
    localparam logic [1:0] ADR_CTRL  = 2'd2;
    localparam logic [1:0] ADR_DIV   = 2'd3;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_FLAG,
        LN_STOP
    } line_state_e;
endpackage

// File: rtl/fas_baud.sv
// Oversample tick generator: a reload counter that pulses `tick` once every
// (D+1) clocks, where D is the divider and a divider of 0 is treated as 1,
// so a tick never occurs on two consecutive cycles.
// Assumes: the divider may change at any time; the new value takes effect
// on the next reload.
module fas_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    // Clamp the divider so the tick is at most half the clock rate.
    always_comb div_eff = (div == '0) ? DIV_W'(1) : div;

    // Count down and reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == '0)   cnt <= div_eff;
        else                  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/fas_tx.sv
// Transmitter: one-byte holding register feeding a shifter.
// Frame: start, 7 or 8 data bits LSB first, optional flag bit, one stop bit.
// A frame begins only on a tick, so every bit lasts exactly OVS ticks.
// `drained` is high when nothing is held and the shifter is idle.
// Assumes: the mode inputs are sampled when a byte enters the shifter.
module fas_tx
    import fas_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              short_char,
    input  logic              flag_mode,
    input  logic              wr_stb,
    input  logic              wr_flag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              drained
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W + 1);

    logic              hold_v;
    logic [DATA_W-1:0] hold_d;
    logic              hold_f;
    line_state_e       st;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [BW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              flag_r;
    logic              flag_en_r;
    logic              txd_r;
    logic              load;
    logic              bit_end;

    always_comb load    = tick && (st == LN_IDLE) && hold_v;
    always_comb bit_end = tick && (tcnt == CW'(OVS - 1));

    // Holding register: accept a write only when empty, release on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
            hold_f <= 1'b0;
        end else begin
            if (load) hold_v <= 1'b0;
            if (wr_stb && !hold_v) begin
                hold_v <= 1'b1;
                hold_d <= wr_data;
                hold_f <= wr_flag;
            end
        end
    end

    // Tick counter within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        tcnt <= '0;
        else if (load)                     tcnt <= '0;
        else if (tick && st != LN_IDLE)    tcnt <= (tcnt == CW'(OVS - 1)) ? '0 : tcnt + 1'b1;
    end

    // Frame sequencer and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= LN_IDLE;
            txd_r     <= 1'b1;
            shreg     <= '0;
            bidx      <= '0;
            last_idx  <= '0;
            flag_r    <= 1'b0;
            flag_en_r <= 1'b0;
        end else begin
            case (st)
                LN_IDLE: if (load) begin
                    st        <= LN_START;
                    txd_r     <= 1'b0;
                    shreg     <= hold_d;
                    flag_r    <= hold_f;
                    flag_en_r <= flag_mode;
                    last_idx  <= short_char ? BW'(DATA_W - 2) : BW'(DATA_W - 1);
                end
                LN_START: if (bit_end) begin
                    st    <= LN_DATA;
                    txd_r <= shreg[0];
                    shreg <= shreg >> 1;
                    bidx  <= '0;
                end
                LN_DATA: if (bit_end) begin
                    if (bidx == last_idx) begin
                        st    <= flag_en_r ? LN_FLAG : LN_STOP;
                        txd_r <= flag_en_r ? flag_r : 1'b1;
                    end else begin
                        bidx  <= bidx + 1'b1;
                        txd_r <= shreg[0];
                        shreg <= shreg >> 1;
                    end
                end
                LN_FLAG: if (bit_end) begin
                    st    <= LN_STOP;
                    txd_r <= 1'b1;
                end
                LN_STOP: if (bit_end) st <= LN_IDLE;
                default: st <= LN_IDLE;
            endcase
        end
    end

    assign txd        = txd_r;
    assign hold_empty = !hold_v;
    assign drained    = !hold_v && (st == LN_IDLE);

    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LN_IDLE) |-> txd_r);
    // R7
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && wr_stb) |=> $stable(hold_d));
endmodule

// File: rtl/fas_rx.sv
// Receiver: synchronises the line and detects a start bit on the ticks.
// The start bit is confirmed at its midpoint, so a shorter glitch is
// rejected. Data and flag bits are sampled every OVS ticks after that.
// Flags are held until the host reads the data register.
// Assumes: the mode inputs are sampled when a start edge is seen.
module fas_rx
    import fas_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              short_char,
    input  logic              flag_mode,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              ready,
    output logic              overrun,
    output logic              frame_err,
    output logic              rx_flag
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W + 1);

    logic              s1, s2;
    line_state_e       st;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [BW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              flag_r, flag_en_r, short_r;
    logic              sample;
    logic              done;
    logic              ready_eff;
    logic [DATA_W-1:0] char_val;

    always_comb sample    = tick && (tcnt == CW'(OVS - 1));
    always_comb done      = sample && (st == LN_STOP);
    always_comb ready_eff = ready && !rd_clr;
    always_comb char_val  = short_r ? {1'b0, shreg[DATA_W-1:1]} : shreg;

    // Two-flop synchroniser, resting at mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    // Frame sequencer: start detection, midpoint check, bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= LN_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            last_idx  <= '0;
            shreg     <= '0;
            flag_r    <= 1'b0;
            flag_en_r <= 1'b0;
            short_r   <= 1'b0;
        end else if (tick) begin
            case (st)
                LN_IDLE: if (!s2) begin
                    st        <= LN_START;
                    tcnt      <= '0;
                    flag_en_r <= flag_mode;
                    short_r   <= short_char;
                    last_idx  <= short_char ? BW'(DATA_W - 2) : BW'(DATA_W - 1);
                end
                LN_START: begin
                    if (tcnt == CW'(OVS / 2 - 1)) begin
                        st   <= s2 ? LN_IDLE : LN_DATA;
                        tcnt <= '0;
                        bidx <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                LN_DATA: begin
                    if (sample) begin
                        tcnt  <= '0;
                        shreg <= {s2, shreg[DATA_W-1:1]};
                        if (bidx == last_idx) st <= flag_en_r ? LN_FLAG : LN_STOP;
                        else                  bidx <= bidx + 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                LN_FLAG: begin
                    if (sample) begin
                        tcnt   <= '0;
                        flag_r <= s2;
                        st     <= LN_STOP;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                LN_STOP: begin
                    if (sample) begin
                        tcnt <= '0;
                        st   <= LN_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= LN_IDLE;
            endcase
        end
    end

    // Receive status: deliver or flag overrun; host read clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            ready     <= 1'b0;
            overrun   <= 1'b0;
            frame_err <= 1'b0;
            rx_flag   <= 1'b0;
        end else begin
            if (rd_clr) begin
                ready     <= 1'b0;
                overrun   <= 1'b0;
                frame_err <= 1'b0;
            end
            if (done) begin
                if (ready_eff) begin
                    overrun <= 1'b1;
                end else begin
                    ready     <= 1'b1;
                    rx_data   <= char_val;
                    frame_err <= !s2;
                    rx_flag   <= flag_en_r && flag_r;
                end
            end
        end
    end

    // R10
    overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(ready));
    // R8
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd_clr) |=> $stable(rx_data));
endmodule

// File: rtl/flagged_async_serial.sv
// Top level: register decode, control and divider registers, and the
// tick generator, transmitter and receiver.
// Assumes: single-cycle bus strobes; reads return combinational data.
module flagged_async_serial
    import fas_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       tx_idle
);
    logic             short_char;
    logic             flag_mode;
    logic [DIV_W-1:0] div;
    logic             tick;
    logic             tx_wr;
    logic             hold_empty;
    logic [DATA_W-1:0] rx_data;
    logic             ready, overrun, frame_err, rx_flag;
    logic             rd_clr;

    // Control and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_char <= 1'b0;
            flag_mode  <= 1'b0;
            div        <= DIV_W'(1);
        end else if (bus_wr) begin
            if (bus_addr == ADR_CTRL) begin
                short_char <= bus_wdata[0];
                flag_mode  <= bus_wdata[1];
            end
            if (bus_addr == ADR_DIV) div <= DIV_W'(bus_wdata);
        end
    end

    always_comb tx_wr  = bus_wr && (bus_addr == ADR_DATA || bus_addr == ADR_FLAG);
    always_comb rd_clr = bus_rd && (bus_addr == ADR_DATA);

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            ADR_DATA: bus_rdata = 8'(rx_data);
            ADR_FLAG: bus_rdata = {2'b00, tx_idle, hold_empty, rx_flag, frame_err, overrun, ready};
            ADR_CTRL: bus_rdata = {6'd0, flag_mode, short_char};
            default:  bus_rdata = 8'(div);
        endcase
    end

    fas_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (div),
        .tick (tick)
    );

    fas_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .short_char(short_char),
        .flag_mode (flag_mode),
        .wr_stb    (tx_wr),
        .wr_flag   (bus_addr == ADR_FLAG),
        .wr_data   (DATA_W'(bus_wdata)),
        .txd       (txd),
        .hold_empty(hold_empty),
        .drained   (tx_idle)
    );

    fas_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .short_char(short_char),
        .flag_mode (flag_mode),
        .rd_clr    (rd_clr),
        .rx_data   (rx_data),
        .ready     (ready),
        .overrun   (overrun),
        .frame_err (frame_err),
        .rx_flag   (rx_flag)
    );

    // R6
    idle_means_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);
endmodule

// File: tb/tb_flagged_async_serial.sv
module tb_flagged_async_serial;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, tx_idle;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    int bit_t = 32;

    flagged_async_serial dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .tx_idle(tx_idle)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp<=%0d cycles", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_char(input logic [7:0] b, input bit s7);
        return s7 ? {1'b0, b[6:0]} : b;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit clr, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = clr;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] d);
        wr(2'd3, d);
        bit_t = 16 * (((d == 0) ? 1 : int'(d)) + 1);
    endtask

    task automatic wait_idle();
        int w = 0;
        while (tx_idle !== 1'b1 && w < 40 * bit_t) begin @(negedge clk); w++; end
    endtask

    task automatic catch_tx(input int nb, input bit hf,
                            output logic [7:0] d, output logic f, output logic sv);
        int w = 0;
        d = 8'd0; f = 1'b0; sv = 1'b0;
        while (txd !== 1'b0 && w < 60 * bit_t) begin @(negedge clk); w++; end
        if (txd !== 1'b0) begin chk(0, 1, "R3 tx frame never started"); return; end
        repeat (bit_t / 2) @(negedge clk);
        chk(txd, 0, "R3 start bit low at midpoint");
        for (int i = 0; i < nb; i++) begin
            repeat (bit_t) @(negedge clk);
            d[i] = txd;
        end
        if (hf) begin repeat (bit_t) @(negedge clk); f = txd; end
        repeat (bit_t) @(negedge clk);
        sv = txd;
    endtask

    task automatic drive_rx(input logic [7:0] b, input bit s7, input bit fm,
                            input bit fv, input bit sv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_t) @(negedge clk);
        for (int i = 0; i < (s7 ? 7 : 8); i++) begin
            rxd = b[i];
            repeat (bit_t) @(negedge clk);
        end
        if (fm) begin rxd = fv; repeat (bit_t) @(negedge clk); end
        rxd = sv;
        repeat (bit_t) @(negedge clk);
        rxd = 1'b1;
        repeat (bit_t) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v, d;
        logic f, sv;
        int lowlen;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd, 1, "R1 txd after reset");
        chk(tx_idle, 1, "R1 tx_idle after reset");
        rd(2'd1, 0, v); chk(v, 8'h30, "R1 status after reset");
        rd(2'd2, 0, v); chk(v, 8'h00, "R1 control after reset");
        rd(2'd3, 0, v); chk(v, 8'h01, "R1 divider after reset");

        // R2 bit length at fastest rate (divider 0 acts as 1) and at divider 3
        set_div(8'd0);
        wr(2'd0, 8'h01);
        while (txd !== 1'b0) @(negedge clk);
        lowlen = 0;
        while (txd === 1'b0) begin lowlen++; @(negedge clk); end
        chk(lowlen, 32, "R2 start bit length divider 0");
        wait_idle();
        set_div(8'd3);
        wr(2'd0, 8'h01);
        while (txd !== 1'b0) @(negedge clk);
        lowlen = 0;
        while (txd === 1'b0) begin lowlen++; @(negedge clk); end
        chk(lowlen, 64, "R2 start bit length divider 3");
        wait_idle();
        set_div(8'd1);

        // R6 holding empties early, drain flag waits for the stop bit
        wr(2'd0, 8'hA5);
        repeat (4) @(negedge clk);
        rd(2'd1, 0, v);
        chk(v[4], 1, "R6 holding empty once shifting");
        chk(v[5], 0, "R6 drained low while shifting");
        catch_tx(8, 0, d, f, sv);
        chk(d, 8'hA5, "R3 tx data 0xA5");
        chk(sv, 1, "R3 stop bit high");
        chk(tx_idle, 0, "R6 tx_idle low during stop bit");
        repeat (bit_t / 2 + 3) @(negedge clk);
        chk(tx_idle, 1, "R6 tx_idle high after stop bit");

        // R7 write into full holding register is dropped
        wr(2'd0, 8'h3C);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'hC3);
        wr(2'd0, 8'h77);
        catch_tx(8, 0, d, f, sv);
        chk(d, 8'h3C, "R7 first frame");
        catch_tx(8, 0, d, f, sv);
        chk(d, 8'hC3, "R7 second frame");
        wait_idle();
        lowlen = 0;
        repeat (12 * bit_t) begin @(negedge clk); if (txd === 1'b0) lowlen++; end
        chk(lowlen, 0, "R7 dropped byte never sent");

        // R5 flag bit with both values, directed
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h81);
        catch_tx(8, 1, d, f, sv);
        chk(d, 8'h81, "R5 flagged data");
        chk(f, 1, "R5 flag slot high for address 1");
        chk(sv, 1, "R5 stop after flag");
        wait_idle();
        wr(2'd0, 8'h81);
        catch_tx(8, 1, d, f, sv);
        chk(f, 0, "R5 flag slot low for address 0");
        wait_idle();

        // Random mixed modes: tx and rx
        for (int k = 0; k < 14; k++) begin
            bit s7, fm, fl;
            logic [7:0] b;
            s7 = 1'($urandom % 2);
            fm = 1'($urandom % 2);
            fl = 1'($urandom % 2);
            b  = 8'($urandom % 256);
            wr(2'd2, {6'd0, fm, s7});
            wr(fl ? 2'd1 : 2'd0, b);
            catch_tx(s7 ? 7 : 8, fm, d, f, sv);
            chk(d, exp_char(b, s7), "R3 R4 random tx data");
            if (fm) chk(f, fl, "R5 random tx flag");
            chk(sv, 1, "R3 random tx stop");
            wait_idle();
            drive_rx(b, s7, fm, fl, 1'b1);
            rd(2'd1, 0, v);
            chk(v[0], 1, "R8 random rx ready");
            chk(v[3], fm & fl, "R9 random rx flag");
            chk(v[2], 0, "R11 no framing error on good stop");
            rd(2'd0, 1, v);
            chk(v, exp_char(b, s7), "R4 R8 random rx data");
            rd(2'd1, 0, v);
            chk(v[2:0], 3'b000, "R8 read clears receive flags");
        end

        // R4 directed: 7-bit receive of a byte with bit 7 set
        wr(2'd2, 8'h01);
        drive_rx(8'hFF, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(2'd0, 1, v);
        chk(v, 8'h7F, "R4 seven-bit receive top bit zero");
        wr(2'd2, 8'h00);

        // R10 overrun keeps first byte
        drive_rx(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
        drive_rx(8'hA7, 1'b0, 1'b0, 1'b0, 1'b1);
        rd(2'd1, 0, v);
        chk(v[1:0], 2'b11, "R10 overrun and ready set");
        rd(2'd0, 1, v);
        chk(v, 8'h5A, "R10 first byte kept");
        rd(2'd1, 0, v);
        chk(v[1:0], 2'b00, "R8 overrun cleared by read");

        // R10 read during second character: no overrun
        drive_rx(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
        fork
            drive_rx(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
            begin
                repeat (5 * bit_t) @(negedge clk);
                rd(2'd0, 1, v);
                chk(v, 8'h11, "R10 first byte read mid-frame");
            end
        join
        rd(2'd1, 0, v);
        chk(v[1:0], 2'b01, "R10 second byte ready without overrun");
        rd(2'd0, 1, v);
        chk(v, 8'h22, "R10 second byte delivered");

        // R11 framing error
        drive_rx(8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd1, 0, v);
        chk(v[2], 1, "R11 framing error set");
        chk(v[0], 1, "R11 byte still delivered");
        rd(2'd0, 1, v);
        chk(v, 8'h96, "R11 data with bad stop");

        // R12 glitch rejection
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * bit_t) @(negedge clk);
        rd(2'd1, 0, v);
        chk(v[0], 0, "R12 glitch does not deliver");
        drive_rx(8'h4E, 1'b0, 1'b0, 1'b0, 1'b1);
        rd(2'd0, 1, v);
        chk(v, 8'h4E, "R12 clean byte after glitch");

        summary();
        $finish;
    end
endmodule